// File: doc/BRIEF.md
# Single-Port Memory with Sleep, Retention and Wake Control

This block is a behavioural synchronous single-port memory that a power controller can put into one of three low-power states. In light sleep the memory keeps its contents and its read port holds the last value. In deep sleep the contents are also kept, but the read port is forced to zero. In shutdown the read port is forced to zero and all stored words are lost. A lost word then reads back as a fixed poison pattern until it is written again.

When the sleep requests are released, the memory becomes usable again only after a wake time. That time depends on the state it is leaving: deeper states take longer. A `ready` output shows when accesses are accepted. Any access attempted while `ready` is low is dropped. The block then raises `err` for one cycle. The power controller must therefore assert sleep requests only in idle periods. It must also release them early enough to cover the wake time before the next access.

Top module: `sram_pm`

## Requirements
- R1: With `ready` high, a write (`en`=1, `we`=1) stores `wdata` at `addr`, and a read (`en`=1, `we`=0) presents the stored word on `rdata` after the next rising edge. `rdata` keeps that value until another read or a sleep state changes it.
- R2: While only `light_req` is asserted, no stored word changes and `rdata` holds its value.
- R3: From the first edge that samples `deep_req` or `off_req`, `rdata` is 0. A deep sleep that is not combined with `off_req` keeps every stored word.
- R4: Shutdown (`off_req`) invalidates every word. Until a word is rewritten, a read of it returns the parameter `POISON` (default 0xA5A5). The same holds for every word after reset.
- R5: When several requests are asserted together, shutdown wins over deep sleep and deep sleep wins over light sleep. This applies to the retention rule, the output rule and the wake time.
- R6: `ready` is low from the first edge that samples any request. After the requests drop, `ready` stays low for L further edges and then rises. L is 1 after light sleep, `DEEP_WAKE` (default 4) after deep sleep and `OFF_WAKE` (default 8) after shutdown, taken from the state in force on the last sleeping cycle.
- R7: An access with `ready` low does nothing: no word is written and `rdata` is unchanged. `err` is high for exactly the cycle after each such attempt and is low otherwise.
- R8: After reset, `ready` is 1, `err` is 0 and `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| light_req | input | 1 | Request light sleep |
| deep_req | input | 1 | Request deep sleep |
| off_req | input | 1 | Request shutdown |
| ready | output | 1 | Accesses are accepted |
| err | output | 1 | Previous cycle held a rejected access |

## Verification
Every result is registered, so read data, `err` and the fall of `ready` all appear one edge after the inputs that cause them. The wake time after a released request adds L more edges before `ready` rises. The bench drives inputs after the falling edge, updates a reference model once per step, and compares all three outputs shortly after the following rising edge. Wake times are measured by counting idle steps with `ready` low after a request drops, and compared with 1, `DEEP_WAKE` and `OFF_WAKE`.

// File: rtl/sram_pm.sv
module sram_pm #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int DEEP_WAKE = 4,
  parameter int OFF_WAKE = 8,
  parameter logic [DW-1:0] POISON = 16'hA5A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          light_req,
  input  logic          deep_req,
  input  logic          off_req,
  output logic          ready,
  output logic          err
);
  localparam int DEPTH = 1 << AW;
  localparam int MAXW  = (DEEP_WAKE > OFF_WAKE) ? DEEP_WAKE : OFF_WAKE;
  localparam int CW    = $clog2(MAXW + 1);

  typedef enum logic [1:0] {AWAKE, LIGHT, DEEP, OFF} pmode_t;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] valid;
  logic [DW-1:0]    dout;
  pmode_t           mode, want;
  logic [CW-1:0]    cnt, lat;

  assign want  = off_req ? OFF : deep_req ? DEEP : light_req ? LIGHT : AWAKE;
  assign ready = (mode == AWAKE) && (cnt == '0);
  assign rdata = dout;

  always_comb begin
    case (mode)
      LIGHT:   lat = CW'(1);
      DEEP:    lat = CW'(DEEP_WAKE);
      OFF:     lat = CW'(OFF_WAKE);
      default: lat = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (en && ready && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= AWAKE;
      cnt   <= '0;
      dout  <= '0;
      valid <= '0;
      err   <= 1'b0;
    end else begin
      err <= en && !ready;
      if (en && ready) begin
        if (we) valid[addr] <= 1'b1;
        else    dout <= valid[addr] ? mem[addr] : POISON;
      end
      if (want != AWAKE) begin
        mode <= want;
        cnt  <= '0;
        if (want == OFF) valid <= '0;
        if (want == OFF || want == DEEP) dout <= '0;
      end else if (mode != AWAKE) begin
        mode <= AWAKE;
        cnt  <= lat;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sram_pm_chk.sv
module sram_pm_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [DW-1:0] rdata,
  input logic          light_req,
  input logic          deep_req,
  input logic          off_req,
  input logic          ready,
  input logic          err
);
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(en && !ready)); // R7
  AST_READY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !err); // R7
  AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (light_req || deep_req || off_req) |=> !ready); // R6
  AST_DEEP_OUT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (deep_req || off_req) |=> (rdata == '0)); // R3
  AST_IDLE_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !deep_req && !off_req) |=> $stable(rdata)); // R2
endmodule

bind sram_pm sram_pm_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rdata(rdata),
  .light_req(light_req), .deep_req(deep_req), .off_req(off_req),
  .ready(ready), .err(err)
);

// File: tb/sim_sram_pm.sv
module sim_sram_pm;
  localparam int DW = 16, AW = 6, DEPTH = 1 << AW;
  localparam int DEEP_WAKE = 4, OFF_WAKE = 8;
  localparam logic [DW-1:0] POISON = 16'hA5A5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, we = 0, light_req = 0, deep_req = 0, off_req = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic ready, err;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sram_pm #(.DW(DW), .AW(AW), .DEEP_WAKE(DEEP_WAKE), .OFF_WAKE(OFF_WAKE), .POISON(POISON)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .light_req(light_req), .deep_req(deep_req), .off_req(off_req), .ready(ready), .err(err));

  logic [DW-1:0] m_mem [DEPTH];
  bit m_val [DEPTH];
  int m_mode = 0, m_cnt = 0;
  logic [DW-1:0] m_dout = '0;
  bit m_err = 0;

  function automatic int wake_of(int m);
    return (m == 3) ? OFF_WAKE : (m == 2) ? DEEP_WAKE : (m == 1) ? 1 : 0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit e, bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [2:0] rq);
    int sel = rq[2] ? 3 : rq[1] ? 2 : rq[0] ? 1 : 0;
    bit rdy = (m_mode == 0) && (m_cnt == 0);
    m_err = e && !rdy;
    if (e && rdy) begin
      if (w) begin m_mem[a] = d; m_val[a] = 1; end
      else m_dout = m_val[a] ? m_mem[a] : POISON;
    end
    if (sel != 0) begin
      if (sel == 3) foreach (m_val[i]) m_val[i] = 0;
      if (sel >= 2) m_dout = '0;
      m_mode = sel; m_cnt = 0;
    end else if (m_mode != 0) begin
      m_cnt = wake_of(m_mode); m_mode = 0;
    end else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic step(bit e, bit w, logic [AW-1:0] a, logic [DW-1:0] d, logic [2:0] rq);
    string dtag;
    en = e; we = w; addr = a; wdata = d;
    {off_req, deep_req, light_req} = rq;
    model(e, w, a, d, rq);
    @(posedge clk); #1;
    dtag = (m_mode == 1) ? "R2" : (m_mode >= 2) ? "R3" : "R1";
    check({dtag, " rdata"}, rdata, m_dout);
    check("R6 ready", DW'(ready), DW'((m_mode == 0) && (m_cnt == 0)));
    check("R7 err", DW'(err), DW'(m_err));
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, '0, '0, 3'b000); endtask

  task automatic wake_len(logic [2:0] rq, int exp, string tag);
    int n = 0;
    step(0, 0, '0, '0, rq);
    step(0, 0, '0, '0, rq);
    for (int k = 0; k < 40; k++) begin
      idle();
      if (ready) break;
      n++;
    end
    check({tag, " wake"}, DW'(n), DW'(exp));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    foreach (m_val[i]) m_val[i] = 0;
    @(negedge clk); @(negedge clk);
    check("R8 ready", DW'(ready), 16'd1);
    check("R8 err", DW'(err), 16'd0);
    check("R8 rdata", rdata, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 never-written word reads poison after reset
    step(1, 0, 6'd3, '0, 3'b000);
    check("R4 reset poison", rdata, POISON);
    // R1 write then read
    step(1, 1, 6'd5, 16'h1234, 3'b000);
    step(1, 0, 6'd5, '0, 3'b000);
    check("R1 readback", rdata, 16'h1234);
    // R2 light sleep holds output and keeps data
    wake_len(3'b001, 1, "R6 light");
    check("R2 hold", rdata, 16'h1234);
    step(1, 0, 6'd5, '0, 3'b000);
    check("R2 retained", rdata, 16'h1234);
    // R3 deep sleep retains, output low
    step(0, 0, '0, '0, 3'b010);
    check("R3 low", rdata, 16'h0000);
    wake_len(3'b010, DEEP_WAKE, "R6 deep");
    step(1, 0, 6'd5, '0, 3'b000);
    check("R3 retained", rdata, 16'h1234);
    // R7 access while waking is dropped
    step(0, 0, '0, '0, 3'b001);
    step(1, 1, 6'd5, 16'hDEAD, 3'b000);
    check("R7 err next", DW'(err), 16'd1);
    check("R7 rdata unchanged", rdata, 16'h1234);
    idle();
    check("R7 err one cycle", DW'(err), 16'd0);
    step(1, 0, 6'd5, '0, 3'b000);
    check("R7 no write", rdata, 16'h1234);
    // R4 shutdown loses data; R5 all requests behave as shutdown
    step(1, 1, 6'd9, 16'h0BEE, 3'b000);
    wake_len(3'b111, OFF_WAKE, "R5 priority");
    step(1, 0, 6'd5, '0, 3'b000);
    check("R4 lost", rdata, POISON);
    step(1, 1, 6'd5, 16'h7777, 3'b000);
    step(1, 0, 6'd5, '0, 3'b000);
    check("R4 rewritten", rdata, 16'h7777);
    wake_len(3'b011, DEEP_WAKE, "R5 deep over light");
    wake_len(3'b100, OFF_WAKE, "R6 off");
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] rq = ($urandom_range(0, 15) == 0) ? 3'($urandom) : 3'b000;
      step(1'($urandom), 1'($urandom), AW'($urandom), DW'($urandom), rq);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule